// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block links two bidirectional data buses, called A and B, through a pair of storage registers, one per direction. Each register has its own capture strobe: the A-to-B register stores the A bus and the B-to-A register stores the B bus. The strobes are plain level inputs sampled by the system clock. A register loads on the system clock edge that follows a detected low-to-high transition of its strobe.

An active-low enable and a direction input decide which bus, if either, the block drives. For each direction, a select input chooses the driven value. It is either the live data from the opposite bus or the contents of that direction's register. Every driven value is the bitwise inverse of its source. With the enable deasserted, the block drives neither bus, but both registers keep capturing.

Each bus is modelled as three separate vectors: an input vector, an output vector and an output-enable flag. There are no inout ports. When a bus is driven, its capture register stores the value the block itself puts on that bus. The system clock, reset and the capture path make up the whole block. There are no pads or tristate cells.

Top module: `dual_reg_xcvr`

## Requirements
- R1: After `cap_ab` is sampled high by the system clock while it was low at the previous sample, the A-to-B register takes the A bus value on the next system clock edge. The register does not change on the sampling edge itself. With the default `SYNC_STAGES=1`, a strobe set before edge k makes the register load at edge k+1.
- R2: `cap_ba` loads the B-to-A register from the B bus with the same timing as R1.
- R3: While `oe_n` is 1 (isolation), `a_oe` and `b_oe` are both 0.
- R4: In isolation, both registers still capture on their strobes. The captured value is `a_in` for the A-to-B register and `b_in` for the B-to-A register.
- R5: With `oe_n`=0, the `dir_atob` input chooses the driven bus. When `dir_atob`=1, `b_oe`=1 and `a_oe`=0. When `dir_atob`=0, `a_oe`=1 and `b_oe`=0.
- R6: While B is driven, `sel_ab` chooses its source. When `sel_ab`=0, `b_out` equals ~`a_in`. When `sel_ab`=1, `b_out` equals ~(A-to-B register).
- R7: While A is driven, `sel_ba` chooses its source. When `sel_ba`=0, `a_out` equals ~`b_in`. When `sel_ba`=1, `a_out` equals ~(B-to-A register).
- R8: While a register drives its bus (`sel`=1), a capture still loads it. The driven output changes to the inverse of the new contents on the load edge and not earlier.
- R9: `a_oe` and `b_oe` are never 1 together.
- R10: A capture from a bus the block is driving stores the driven value. It does not store the value on the bus input vector.
- R11: An output vector whose enable is 0 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the strobe samplers |
| oe_n | input | 1 | Active-low output enable |
| dir_atob | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_ab | input | 1 | Source for B: 0 live A, 1 A-to-B register |
| sel_ba | input | 1 | Source for A: 0 live B, 1 B-to-A register |
| cap_ab | input | 1 | Capture strobe of the A-to-B register |
| cap_ba | input | 1 | Capture strobe of the B-to-A register |
| a_in | input | W | A bus input data |
| a_out | output | W | A bus output data |
| a_oe | output | 1 | A bus output enable |
| b_in | input | W | B bus input data |
| b_out | output | W | B bus output data |
| b_oe | output | 1 | B bus output enable |

## Verification
The hardest cases to reach are a capture into a register that is driving its own bus, and a capture from a bus the block is driving. Both need a register with known contents before the strobe, and the second needs the other register selected as the driving source. The stimulus first loads both registers in isolation. It then runs directed sequences that pulse a strobe in stored mode, checking the output between the sampling edge and the load edge. Random modes, data and strobes follow, with a bench model tracking both registers.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {SRC_LIVE = 1'b0, SRC_STORED = 1'b1} src_e;

   typedef struct packed {
      logic drive_a;
      logic drive_b;
   } drive_t;
endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge #(
   parameter int SYNC_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic rise
);
   localparam int DEPTH = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 1) begin : g_bad
         $error("xcvr_strobe_edge: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] hist;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist <= '0;
            else        hist <= {hist[0], strobe};
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist <= '0;
            else        hist <= {hist[DEPTH-2:0], strobe};
         end
      end
   endgenerate

   assign rise = hist[DEPTH-2] & ~hist[DEPTH-1];
endmodule

// File: rtl/xcvr_dir_ctl.sv
module xcvr_dir_ctl
   import xcvr_pkg::*;
(
   input  logic   oe_n,
   input  logic   dir_atob,
   output drive_t drv
);
   always_comb begin
      drv.drive_b = ~oe_n &  dir_atob;
      drv.drive_a = ~oe_n & ~dir_atob;
   end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         load,
   input  logic [W-1:0] cap_data,
   input  logic [W-1:0] live_data,
   input  src_e         src,
   input  logic         drive,
   output logic [W-1:0] out_data
);
   logic [W-1:0] store_q;
   logic [W-1:0] chosen;

   always_ff @(posedge clk) begin
      if (load) store_q <= cap_data;
   end

   assign chosen   = (src == SRC_STORED) ? store_q : live_data;
   assign out_data = drive ? ~chosen : '0;
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
   import xcvr_pkg::*;
#(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         oe_n,
   input  logic         dir_atob,
   input  logic         sel_ab,
   input  logic         sel_ba,
   input  logic         cap_ab,
   input  logic         cap_ba,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] b_out,
   output logic         b_oe
);
   generate
      if (W < 1) begin : g_bad_w
         $error("dual_reg_xcvr: W must be at least 1");
      end
   endgenerate

   drive_t       drv;
   logic         rise_ab;
   logic         rise_ba;
   logic [W-1:0] a_bus;
   logic [W-1:0] b_bus;

   xcvr_dir_ctl u_dir (
      .oe_n     (oe_n),
      .dir_atob (dir_atob),
      .drv      (drv)
   );

   xcvr_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_ab (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (cap_ab),
      .rise   (rise_ab)
   );

   xcvr_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_ba (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (cap_ba),
      .rise   (rise_ba)
   );

   // the value seen on each bus: driven value when the block drives it
   assign a_bus = drv.drive_a ? a_out : a_in;
   assign b_bus = drv.drive_b ? b_out : b_in;

   xcvr_lane #(.W(W)) u_lane_ab (
      .clk       (clk),
      .load      (rise_ab),
      .cap_data  (a_bus),
      .live_data (a_in),
      .src       (src_e'(sel_ab)),
      .drive     (drv.drive_b),
      .out_data  (b_out)
   );

   xcvr_lane #(.W(W)) u_lane_ba (
      .clk       (clk),
      .load      (rise_ba),
      .cap_data  (b_bus),
      .live_data (b_in),
      .src       (src_e'(sel_ba)),
      .drive     (drv.drive_a),
      .out_data  (a_out)
   );

   assign a_oe = drv.drive_a;
   assign b_oe = drv.drive_b;
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         oe_n,
   input logic         dir_atob,
   input logic         sel_ab,
   input logic         sel_ba,
   input logic         rise_ab,
   input logic [W-1:0] a_in,
   input logic [W-1:0] b_in,
   input logic [W-1:0] a_out,
   input logic [W-1:0] b_out,
   input logic         a_oe,
   input logic         b_oe
);
   // R9
   both_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_oe && b_oe));

   // R3
   iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!a_oe && !b_oe));

   // R5
   dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n) |-> ((b_oe == dir_atob) && (a_oe == !dir_atob)));

   // R6
   live_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe && !sel_ab) |-> (b_out == ~a_in));

   // R7
   live_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe && !sel_ba) |-> (a_out == ~b_in));

   // R11
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!a_oe) |-> (a_out == '0)) and ((!b_oe) |-> (b_out == '0)));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe && sel_ab && $past(b_oe && sel_ab) && !$past(rise_ab))
      |-> $stable(b_out));
endmodule

bind dual_reg_xcvr xcvr_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .oe_n     (oe_n),
   .dir_atob (dir_atob),
   .sel_ab   (sel_ab),
   .sel_ba   (sel_ba),
   .rise_ab  (rise_ab),
   .a_in     (a_in),
   .b_in     (b_in),
   .a_out    (a_out),
   .b_out    (b_out),
   .a_oe     (a_oe),
   .b_oe     (b_oe)
);

// File: tb/sim_dual_reg_xcvr.sv
module sim_dual_reg_xcvr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       oe_n = 1'b1, dir_atob = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
   logic       cap_ab = 1'b0, cap_ba = 1'b0;
   logic [7:0] a_in = '0, b_in = '0;
   logic [7:0] a_out, b_out;
   logic       a_oe, b_oe;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] m_ab, m_ba;
   bit done = 0;

   always #2.5 clk = ~clk;

   dual_reg_xcvr #(.W(8), .SYNC_STAGES(1)) u0 (
      .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir_atob(dir_atob),
      .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

   function automatic logic exp_b_oe();
      return !oe_n && dir_atob;
   endfunction
   function automatic logic exp_a_oe();
      return !oe_n && !dir_atob;
   endfunction
   function automatic logic [7:0] exp_b_out();
      if (!exp_b_oe()) return 8'h00;
      return sel_ab ? ~m_ab : ~a_in;
   endfunction
   function automatic logic [7:0] exp_a_out();
      if (!exp_a_oe()) return 8'h00;
      return sel_ba ? ~m_ba : ~b_in;
   endfunction

   task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(string req);
      chk8({req, " a_oe"}, {7'd0, a_oe}, {7'd0, exp_a_oe()});
      chk8({req, " b_oe"}, {7'd0, b_oe}, {7'd0, exp_b_oe()});
      chk8({req, " a_out"}, a_out, exp_a_out());
      chk8({req, " b_out"}, b_out, exp_b_out());
      // R9
      chk8("R9 both enables", {7'd0, a_oe && b_oe}, 8'h00);
   endtask

   // strobe pulse; bus inputs and modes stay fixed until the load edge
   task automatic pulse(bit do_ab, bit do_ba);
      logic [7:0] na, nb;
      @(negedge clk);
      cap_ab = do_ab; cap_ba = do_ba;
      @(negedge clk);
      na = exp_a_oe() ? exp_a_out() : a_in;
      nb = exp_b_oe() ? exp_b_out() : b_in;
      @(negedge clk);
      if (do_ab) m_ab = na;
      if (do_ba) m_ba = nb;
      cap_ab = 0; cap_ba = 0;
      @(negedge clk);
   endtask

   task automatic set_mode(logic oen, logic dir, logic sab, logic sba);
      @(negedge clk);
      oe_n = oen; dir_atob = dir; sel_ab = sab; sel_ba = sba;
      #1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R3 R11: reset state, isolation
      check_all("R3 R11 reset");

      // R4 R1 R2: capture in isolation
      a_in = 8'h3C; b_in = 8'hA5;
      pulse(1, 1);
      a_in = 8'h00; b_in = 8'h00;
      set_mode(0, 1, 1, 0);
      check_all("R1 R4 R5 R6 stored AB");
      chk8("R1 stored AB", b_out, 8'hC3);
      set_mode(0, 0, 0, 1);
      check_all("R2 R4 R5 R7 stored BA");
      chk8("R2 stored BA", a_out, 8'h5A);

      // R6 R7 live paths
      set_mode(0, 1, 0, 0);
      a_in = 8'h0F; #1;
      chk8("R6 live B", b_out, 8'hF0);
      chk8("R11 idle A", a_out, 8'h00);
      set_mode(0, 0, 0, 0);
      b_in = 8'h81; #1;
      chk8("R7 live A", a_out, 8'h7E);

      // R8 R1: stored mode, load while driving, output changes only at load
      set_mode(0, 1, 1, 0);
      a_in = 8'h55;
      @(negedge clk); cap_ab = 1;
      @(negedge clk); #1;
      chk8("R1 R8 before load", b_out, 8'hC3);
      @(negedge clk); #1;
      chk8("R1 R8 after load", b_out, 8'hAA);
      m_ab = 8'h55;
      cap_ab = 0;
      @(negedge clk);

      // R10: A driven from stored BA (~A5 = 5A); a_in differs
      set_mode(0, 0, 0, 1);
      a_in = 8'hFF;
      pulse(1, 0);
      set_mode(0, 1, 1, 0);
      chk8("R10 driven capture", b_out, 8'hA5);
      // R10 on B: B driven live from a_in=FF -> 00 captured into BA
      set_mode(0, 1, 0, 0);
      b_in = 8'h77;
      pulse(0, 1);
      set_mode(0, 0, 0, 1);
      chk8("R10 driven capture B", a_out, 8'hFF);

      // R2 R8 on BA side: stored mode reload
      b_in = 8'h3A;
      set_mode(1, 0, 0, 1);
      pulse(0, 1);
      set_mode(0, 0, 0, 1);
      chk8("R2 R4 R7 reload", a_out, 8'hC5);

      // random mixed stimulus
      void'($urandom(32'd1234));
      for (int i = 0; i < 400; i++) begin
         logic [3:0] m;
         logic [1:0] p;
         m = 4'($urandom);
         p = 2'($urandom);
         set_mode(m[0], m[1], m[2], m[3]);
         a_in = 8'($urandom); b_in = 8'($urandom); #1;
         check_all("R3 R5 R6 R7 R11 random");
         if (p != 2'b00) begin
            pulse(p[0], p[1]);
            #1;
            check_all("R1 R2 R4 R8 R10 random load");
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule